// File: doc/BRIEF.md
# Pause hint decode and stall unit

This unit sits beside the decode stage of a simple in-order pipeline and inspects every instruction word offered to it. When the word is the pause hint it holds the issue stage for a bounded number of cycles and then emits a one-cycle retire pulse, so the hint completes as a no-op. The hint is a memory-ordering fence with the write-only predecessor set, an empty successor set, a zero fence-mode field and x0 as both source and destination. Any other fence form passes through without effect.

The stall has two phases. The first is an optional drain phase, selected per hint, that waits for the outstanding memory transaction count to reach zero and is cut off by a cycle cap. The second is a fixed delay taken from a delay input at the moment the hint is accepted. A delay of zero with no drain retires the hint at once without any stall cycle. The unit drives only the stall and retire outputs. It issues no register write and no memory request.

Top module: `pause_hint_unit`

## Requirements
- R1: Field layout: opcode in bits [6:0], rd in [11:7], funct3 in [14:12], rs1 in [19:15], successor set in [23:20], predecessor set in [27:24] (bit 24 = write), fm in [31:28]. Only the word 32'h0100000F with `instr_valid_i` high starts a pause. The same word with the valid flag low does nothing.
- R2: A word that differs from 32'h0100000F in any field produces no stall and no retire pulse. This covers a nonzero successor set, a nonzero fm, a nonzero rd or rs1, another predecessor set, another funct3 and another opcode.
- R3: With drain off and a delay D of 1 or more, `stall_o` is high for exactly D consecutive cycles starting the cycle after acceptance, and `retire_o` is high in the cycle that follows the last stall cycle.
- R4: With drain off and a delay of 0, `stall_o` never rises, and `retire_o` is high in the cycle after acceptance.
- R5: With drain on, the drain phase lasts until the cycle in which the outstanding count is sampled as zero, and that cycle is included. The phase is at least one cycle long. The D delay cycles follow it. The total stall equals the drain cycles plus D.
- R6: The drain phase lasts at most MAX_DRAIN cycles even if the outstanding count never reaches zero.
- R7: `retire_o` lasts exactly one cycle per hint, and `retire_o` and `stall_o` are never high together.
- R8: While a hint is stalling or retiring, new words on the input are ignored. The delay value is captured when the hint is accepted.
- R9: Hints presented back to back each produce their own stall and their own retire pulse. The total stall is the sum of the individual stalls.
- R10: While reset is asserted and directly after it, `stall_o` and `retire_o` are low.
- R11: No single pause stalls for more than MAX_DRAIN + 2^DELAY_W - 1 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word from decode |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| outstanding_i | input | OUTST_W | Number of memory transactions in flight |
| drain_en_i | input | 1 | Wait for memory to drain before the delay |
| delay_i | input | DELAY_W | Fixed stall length in cycles, captured at acceptance |
| stall_o | output | 1 | Hold the issue stage |
| retire_o | output | 1 | One-cycle pulse that retires the hint |

## Verification
The assertions assume that the instruction word, the valid flag, the delay and the drain enable are settled at each rising edge. They also assume that a hint accepted with stall and retire both low finds the unit idle. The bench changes every input on the falling edge, so each input is stable across the edge that samples it. While a hint is running, the outstanding count is changed only at counted falling edges, so the length of the drain phase follows directly from the stimulus.

// File: rtl/pause_pkg.sv
package pause_pkg;

  typedef struct packed {
    logic [3:0] fm;
    logic [3:0] pred;
    logic [3:0] succ;
    logic [4:0] rs1;
    logic [2:0] funct3;
    logic [4:0] rd;
    logic [6:0] opcode;
  } fence_word_t;

  localparam logic [6:0] OPC_MISC_MEM = 7'b0001111;
  localparam logic [2:0] F3_FENCE     = 3'b000;
  localparam logic [3:0] PRED_W_ONLY  = 4'b0001;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_COUNT,
    ST_DONE
  } pause_state_e;

endpackage

// File: rtl/pause_decode.sv
module pause_decode
  import pause_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic        valid_i,
  output logic        hit_o
);

  fence_word_t w;
  assign w = fence_word_t'(instr_i);

  always_comb begin
    hit_o = valid_i
         && (w.opcode == OPC_MISC_MEM)
         && (w.funct3 == F3_FENCE)
         && (w.rd     == 5'd0)
         && (w.rs1    == 5'd0)
         && (w.succ   == 4'd0)
         && (w.pred   == PRED_W_ONLY)
         && (w.fm     == 4'd0);
  end

endmodule

// File: rtl/pause_timer.sv
module pause_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (load_i)               cnt_o <= load_val_i;
    else if (dec_i && cnt_o != '0) cnt_o <= cnt_o - W'(1);
  end

endmodule

// File: rtl/pause_fsm.sv
module pause_fsm
  import pause_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hit_i,
  input  logic         drain_en_i,
  input  logic         delay_zero_i,
  input  logic         mem_idle_i,
  input  logic         drain_cap_i,
  input  logic         cnt_zero_i,
  input  logic         cnt_last_i,
  output logic         accept_o,
  output pause_state_e state_o
);

  pause_state_e state_d;

  always_comb begin
    state_d  = state_o;
    accept_o = 1'b0;
    unique case (state_o)
      ST_IDLE: if (hit_i) begin
        accept_o = 1'b1;
        if (drain_en_i)        state_d = ST_DRAIN;
        else if (delay_zero_i) state_d = ST_DONE;
        else                   state_d = ST_COUNT;
      end
      // leave drain on empty memory or on the cap, whichever comes first
      ST_DRAIN: if (mem_idle_i || drain_cap_i)
        state_d = cnt_zero_i ? ST_DONE : ST_COUNT;
      ST_COUNT: if (cnt_last_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
  end

endmodule

// File: rtl/pause_hint_unit.sv
module pause_hint_unit
  import pause_pkg::*;
#(
  parameter int DELAY_W   = 8,
  parameter int OUTST_W   = 4,
  parameter int MAX_DRAIN = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        instr_i,
  input  logic               instr_valid_i,
  input  logic [OUTST_W-1:0] outstanding_i,
  input  logic               drain_en_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               stall_o,
  output logic               retire_o
);

  localparam int DRAIN_W = (MAX_DRAIN > 2) ? $clog2(MAX_DRAIN) : 1;
  localparam logic [DRAIN_W-1:0] DRAIN_LOAD = DRAIN_W'(MAX_DRAIN - 1);

  logic               hit, accept;
  logic [DELAY_W-1:0] delay_cnt;
  logic [DRAIN_W-1:0] drain_cnt;
  pause_state_e       state;

  pause_decode u_decode (
    .instr_i (instr_i),
    .valid_i (instr_valid_i),
    .hit_o   (hit)
  );

  // delay captured at acceptance, consumed only in ST_COUNT
  pause_timer #(.W(DELAY_W)) u_delay_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (delay_i),
    .dec_i      (state == ST_COUNT),
    .cnt_o      (delay_cnt)
  );

  pause_timer #(.W(DRAIN_W)) u_drain_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (DRAIN_LOAD),
    .dec_i      (state == ST_DRAIN),
    .cnt_o      (drain_cnt)
  );

  pause_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .drain_en_i   (drain_en_i),
    .delay_zero_i (delay_i == '0),
    .mem_idle_i   (outstanding_i == '0),
    .drain_cap_i  (drain_cnt == '0),
    .cnt_zero_i   (delay_cnt == '0),
    .cnt_last_i   (delay_cnt == DELAY_W'(1)),
    .accept_o     (accept),
    .state_o      (state)
  );

  assign stall_o  = (state == ST_DRAIN) || (state == ST_COUNT);
  assign retire_o = (state == ST_DONE);

endmodule

// File: rtl/pause_hint_chk.sv
module pause_hint_chk #(
  parameter int DELAY_W   = 8,
  parameter int MAX_DRAIN = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [31:0]        instr_i,
  input logic               instr_valid_i,
  input logic               drain_en_i,
  input logic [DELAY_W-1:0] delay_i,
  input logic               stall_o,
  input logic               retire_o
);

  localparam logic [31:0] HINT_WORD = 32'h0100000F;
  localparam int STALL_BOUND = MAX_DRAIN + (2 ** DELAY_W) - 1;

  logic idle_seen, hint_seen;
  int   stall_run;

  assign idle_seen = !stall_o && !retire_o;
  assign hint_seen = instr_valid_i && (instr_i == HINT_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stall_run <= 0;
    else if (stall_o) stall_run <= stall_run + 1;
    else              stall_run <= 0;
  end

  // R2
  non_hint_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_seen && !hint_seen) |=> (!stall_o && !retire_o));

  // R4
  zero_delay_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_seen && hint_seen && !drain_en_i && delay_i == '0) |=> (retire_o && !stall_o));

  // R3
  delay_starts_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_seen && hint_seen && !drain_en_i && delay_i != '0) |=> stall_o);

  // R5
  drain_starts_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_seen && hint_seen && drain_en_i) |=> stall_o);

  // R3
  stall_end_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> retire_o);

  // R7
  retire_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !retire_o);

  // R7
  retire_stall_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(retire_o && stall_o));

  // R11
  stall_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_run <= STALL_BOUND);

endmodule

bind pause_hint_unit pause_hint_chk #(
  .DELAY_W   (DELAY_W),
  .MAX_DRAIN (MAX_DRAIN)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_i       (instr_i),
  .instr_valid_i (instr_valid_i),
  .drain_en_i    (drain_en_i),
  .delay_i       (delay_i),
  .stall_o       (stall_o),
  .retire_o      (retire_o)
);

// File: tb/pause_hint_unit_tb.sv
`timescale 1ns/1ps
module pause_hint_unit_tb;

  localparam int DELAY_W   = 8;
  localparam int OUTST_W   = 4;
  localparam int MAX_DRAIN = 16;
  localparam logic [31:0] HINT = 32'h0100000F;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [31:0]        instr = '0;
  logic               valid = 1'b0;
  logic [OUTST_W-1:0] outst = '0;
  logic               drain = 1'b0;
  logic [DELAY_W-1:0] delay = '0;
  logic               stall, retire;

  int total = 0, failed = 0;
  int exp_q[$];
  int run = 0, retire_cnt = 0, stall_seen = 0;
  logic prev_retire = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pause_hint_unit #(.DELAY_W(DELAY_W), .OUTST_W(OUTST_W), .MAX_DRAIN(MAX_DRAIN)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .instr_i (instr), .instr_valid_i (valid),
    .outstanding_i (outst), .drain_en_i (drain), .delay_i (delay),
    .stall_o (stall), .retire_o (retire)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: counts stall cycles per hint, compares at retire
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stall) begin
        stall_seen++;
        if (exp_q.size() == 0) check(0, "R2 unexpected stall", 1, 0);
        else run++;
      end
      if (stall && retire) check(0, "R7 stall with retire", 1, 0);
      if (retire && prev_retire) check(0, "R7 retire longer than one cycle", 2, 1);
      if (retire) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected retire", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(run == e, "R3/R4/R5/R6 stall length", run, e);
        end
        run = 0;
        retire_cnt++;
      end
      prev_retire = retire;
    end
  end

  task automatic present(input logic [31:0] w, input int d, input bit dr, input int exp);
    @(negedge clk);
    instr = w; valid = 1'b1; delay = DELAY_W'(d); drain = dr;
    if (exp >= 0) exp_q.push_back(exp);
    @(negedge clk);
    valid = 1'b0; instr = '0;
  endtask

  task automatic wait_retires(input int n);
    while (retire_cnt < n) @(negedge clk);
  endtask

  task automatic expect_silent(input logic [31:0] w, input bit v, input string req);
    int r0, s0;
    r0 = retire_cnt; s0 = stall_seen;
    @(negedge clk);
    instr = w; valid = v; delay = 8'd3; drain = 1'b0;
    @(negedge clk);
    valid = 1'b0; instr = '0;
    repeat (5) @(negedge clk);
    check(retire_cnt == r0 && stall_seen == s0, req, retire_cnt - r0 + stall_seen - s0, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    check(0, "watchdog", 0, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int base;
    // R10
    repeat (3) @(negedge clk);
    check(!stall && !retire, "R10 outputs in reset", {stall, retire}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!stall && !retire, "R10 outputs after reset", {stall, retire}, 0);

    // R4 zero delay
    present(HINT, 0, 0, 0);   wait_retires(1);
    // R3 fixed delays, R1 exact word
    present(HINT, 1, 0, 1);   wait_retires(2);
    present(HINT, 5, 0, 5);   wait_retires(3);
    present(HINT, 9, 0, 9);   wait_retires(4);

    // R5 drain with memory already idle
    outst = '0;
    present(HINT, 3, 1, 4);   wait_retires(5);
    present(HINT, 0, 1, 1);   wait_retires(6);
    // R5 memory drains after three cycles
    outst = 4'd3;
    present(HINT, 2, 1, 5);
    repeat (2) @(negedge clk);
    outst = '0;
    wait_retires(7);
    // R6 memory never drains
    outst = 4'd5;
    present(HINT, 2, 1, MAX_DRAIN + 2);  wait_retires(8);
    outst = '0;

    // R2 other fence forms and words
    expect_silent(32'h0FF0000F, 1'b1, "R2 full fence");
    expect_silent(32'h0110000F, 1'b1, "R2 nonzero successor");
    expect_silent(32'h1100000F, 1'b1, "R2 nonzero fm");
    expect_silent(32'h0100008F, 1'b1, "R2 nonzero rd");
    expect_silent(32'h0100800F, 1'b1, "R2 nonzero rs1");
    expect_silent(32'h0200000F, 1'b1, "R2 read predecessor");
    expect_silent(32'h0100100F, 1'b1, "R2 other funct3");
    expect_silent(32'h01000013, 1'b1, "R2 other opcode");
    // R1 valid low
    expect_silent(HINT, 1'b0, "R1 hint without valid");

    // R8 input ignored while busy
    base = retire_cnt;
    present(HINT, 5, 0, 5);
    instr = HINT; valid = 1'b1; delay = 8'd20; drain = 1'b1;
    repeat (3) @(negedge clk);
    valid = 1'b0; instr = '0; drain = 1'b0;
    wait_retires(base + 1);
    repeat (6) @(negedge clk);
    check(retire_cnt == base + 1, "R8 extra hint during stall", retire_cnt - base, 1);

    // R9 back to back
    base = retire_cnt;
    stall_seen = 0;
    repeat (3) exp_q.push_back(4);
    @(negedge clk);
    instr = HINT; valid = 1'b1; delay = 8'd4; drain = 1'b0;
    wait_retires(base + 3);
    valid = 1'b0; instr = '0;
    repeat (6) @(negedge clk);
    check(retire_cnt == base + 3, "R9 retire count", retire_cnt - base, 3);
    check(stall_seen == 12, "R9 cumulative stall", stall_seen, 12);
    check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule